// File: doc/BRIEF.md
# Change-of-State and Level-Match Interrupt Controller

This block watches eight digital input channels and raises one active-low interrupt request when an armed channel sees its selected condition. Each channel can be set to one of two modes. In change-of-state mode it fires on any transition of the input. In level-match mode it fires while the input equals a programmed polarity. Every input passes through a two-flop synchroniser before detection. The detectors compare the synchronised value either with its value one cycle earlier or with the polarity bit.

Software reaches the block through a simple register bus with one access per cycle. It has per-channel enable, status, mode and polarity registers, and a global register. The global register holds an arm bit and a read-only pending flag. Reading the status register disarms the request line, so the line goes high at once. It stays high until software writes 1 to the arm bit again. Status bits are cleared by writing 1 to them.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset, the enable, status, mode and polarity registers read 0. The arm bit reads 0 and `irq_n` is 1.
- R2: The address map is: global = 0, enable = 1, status = 2, mode = 3, polarity = 4. Enable, mode and polarity read back the last value written to them.
- R3: With mode bit = 1 (change of state) and the channel enabled, a rising or a falling input transition sets that channel's status bit. The bit is visible after the third rising clock edge following the input change, and not after the second.
- R4: With mode bit = 0 (level match), an enabled channel's status bit is set whenever its synchronised input equals its polarity bit (0 = low, 1 = high).
- R5: A channel whose enable bit is 0 never sets its status bit, whatever its input does.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R7: Bit 1 of the global register reads 1 exactly when some status bit is set whose enable bit is also 1.
- R8: Writing 1 to bit 0 of the global register sets the arm bit, which reads back in bit 0. `irq_n` is 0 exactly when the arm bit is 1 and the pending condition of R7 holds.
- R9: A read of the status register clears the arm bit. `irq_n` is then 1 from the following cycle, even if status bits remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| chan_in | input | 8 | Asynchronous channel inputs |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An input change reaches the status register and `irq_n` on the third rising edge after it. The bench changes inputs on a falling edge and checks `irq_n` after two edges, where it must be unchanged, and again after three. Register writes and status-read side effects take effect on the edge inside the access. Each read samples `bus_rdata` before that edge, and checks of `irq_n` after an access are made at the next falling edge. Level-mode results are read back only after the enable write's edge, plus one more edge for the status update.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_GLOBAL = 3'd0,
    REG_ENABLE = 3'd1,
    REG_STATUS = 3'd2,
    REG_MODE   = 3'd3,
    REG_POLAR  = 3'd4
  } reg_addr_e;

  localparam int GLB_ARM_BIT  = 0;
  localparam int GLB_PEND_BIT = 1;
endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q, stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/chg_irq_detect.sv
module chg_irq_detect #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sync_i,
  input  logic [NCH-1:0] mode_i,
  input  logic [NCH-1:0] pol_i,
  output logic [NCH-1:0] evt_o
);
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic toggled, matched;
    always_comb begin
      toggled  = sync_i[c] ^ prev_q[c];
      matched  = ~(sync_i[c] ^ pol_i[c]);
      evt_o[c] = mode_i[c] ? toggled : matched;
    end
  end
endmodule

// File: rtl/chg_irq_regs.sv
module chg_irq_regs
  import chg_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCH-1:0]    bus_wdata,
  output logic [NCH-1:0]    bus_rdata,
  input  logic [NCH-1:0]    evt_i,
  output logic [NCH-1:0]    mode_o,
  output logic [NCH-1:0]    pol_o,
  output logic              irq_n_o
);
  logic [NCH-1:0] en_q, en_d, stat_q, stat_d, mode_q, mode_d, pol_q, pol_d, clr;
  logic           glb_q, glb_d, pend;
  logic           wr_glb, wr_en, wr_stat, wr_mode, wr_pol, rd_stat;

  always_comb begin
    wr_glb  = bus_sel & bus_wr & (bus_addr == REG_GLOBAL);
    wr_en   = bus_sel & bus_wr & (bus_addr == REG_ENABLE);
    wr_stat = bus_sel & bus_wr & (bus_addr == REG_STATUS);
    wr_mode = bus_sel & bus_wr & (bus_addr == REG_MODE);
    wr_pol  = bus_sel & bus_wr & (bus_addr == REG_POLAR);
    rd_stat = bus_sel & ~bus_wr & (bus_addr == REG_STATUS);

    en_d   = wr_en   ? bus_wdata : en_q;
    mode_d = wr_mode ? bus_wdata : mode_q;
    pol_d  = wr_pol  ? bus_wdata : pol_q;
    clr    = wr_stat ? bus_wdata : '0;
    stat_d = (stat_q & ~clr) | (evt_i & en_q);

    glb_d = glb_q;
    if (rd_stat)                             glb_d = 1'b0;
    else if (wr_glb && bus_wdata[GLB_ARM_BIT]) glb_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      glb_q  <= 1'b0;
    end else begin
      if (wr_en)   en_q   <= en_d;
      if (wr_mode) mode_q <= mode_d;
      if (wr_pol)  pol_q  <= pol_d;
      stat_q <= stat_d;
      glb_q  <= glb_d;
    end
  end

  always_comb begin
    pend      = |(stat_q & en_q);
    irq_n_o   = ~(glb_q & pend);
    bus_rdata = '0;
    case (bus_addr)
      REG_GLOBAL: begin
        bus_rdata[GLB_ARM_BIT]  = glb_q;
        bus_rdata[GLB_PEND_BIT] = pend;
      end
      REG_ENABLE: bus_rdata = en_q;
      REG_STATUS: bus_rdata = stat_q;
      REG_MODE:   bus_rdata = mode_q;
      REG_POLAR:  bus_rdata = pol_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  p_release_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> irq_n_o);

  p_set_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(en_q)) == '0);

  p_clear_only_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q) & ~stat_q & ~($past(bus_wdata) & {NCH{$past(wr_stat)}})) == '0);

  p_arm_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(glb_q) |-> $past(wr_glb && bus_wdata[GLB_ARM_BIT]));
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCH-1:0]    bus_wdata,
  output logic [NCH-1:0]    bus_rdata,
  input  logic [NCH-1:0]    chan_in,
  output logic              irq_n
);
  logic [1:0]     rst_pipe_q;
  logic           core_rst_n;
  logic [NCH-1:0] sync_val, evt, mode, pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  chg_irq_sync #(.W(NCH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(core_rst_n), .d_i(chan_in), .q_o(sync_val));

  chg_irq_detect #(.NCH(NCH)) u_detect (
    .clk(clk), .rst_n(core_rst_n), .sync_i(sync_val),
    .mode_i(mode), .pol_i(pol), .evt_o(evt));

  chg_irq_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(core_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt), .mode_o(mode), .pol_o(pol), .irq_n_o(irq_n));
endmodule

// File: tb/test_chg_irq_ctrl.sv
`timescale 1ns/1ps
module test_chg_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, chan_in;
  logic       irq_n;
  int         checks = 0, errors = 0;
  logic [7:0] rd_v;

  localparam logic [2:0] A_GLB = 3'd0, A_EN = 3'd1, A_ST = 3'd2, A_MODE = 3'd3, A_POL = 3'd4;

  always #5 clk = ~clk;

  chg_irq_ctrl i_chg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_in(chan_in), .irq_n(irq_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_regs_check();
    chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rd_v);
      chk($sformatf("R1 reg %0d after reset", a), rd_v, 8'h00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; chan_in = 0; rst_n = 1'b0;
    do_reset();
    reset_regs_check();

    // R2 read-back
    wr(A_MODE, 8'h3C); wr(A_POL, 8'h0F); wr(A_EN, 8'hA5);
    rd(A_EN, rd_v);   chk("R2 enable readback", rd_v, 8'hA5);
    rd(A_MODE, rd_v); chk("R2 mode readback", rd_v, 8'h3C);
    rd(A_POL, rd_v);  chk("R2 polarity readback", rd_v, 8'h0F);
    wr(A_GLB, 8'h01);
    rd(A_GLB, rd_v);  chk("R8 arm bit readback", rd_v & 8'h01, 8'h01);
    wr(A_EN, 8'h00); wr(A_ST, 8'hFF);

    // R3 change-of-state sweep, both directions, every channel
    wr(A_MODE, 8'hFF); wr(A_POL, 8'h00); wr(A_EN, 8'hFF); wr(A_ST, 8'hFF);
    rd(A_ST, rd_v); wr(A_GLB, 8'h01);
    for (int dir = 0; dir < 2; dir++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); chan_in[i] = ~chan_in[i];
        repeat (2) @(negedge clk);
        chk($sformatf("R3 ch%0d not yet after 2 edges", i), {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        chk($sformatf("R3 ch%0d irq after 3 edges", i), {7'd0, irq_n}, 8'h00);
        rd(A_GLB, rd_v); chk("R7 pending and armed", rd_v & 8'h03, 8'h03);
        rd(A_ST, rd_v);  chk($sformatf("R3 ch%0d status", i), rd_v, 8'(1 << i));
        chk("R9 irq released after status read", {7'd0, irq_n}, 8'h01);
        wr(A_ST, 8'(1 << i));
        rd(A_ST, rd_v);  chk("R6 status cleared", rd_v, 8'h00);
        rd(A_GLB, rd_v); chk("R7 no pending, disarmed", rd_v & 8'h03, 8'h00);
        wr(A_GLB, 8'h01);
        chk("R8 rearmed with nothing pending", {7'd0, irq_n}, 8'h01);
      end
    end

    // R5 disabled channels ignore activity
    wr(A_EN, 8'h00);
    @(negedge clk); chan_in = ~chan_in;
    repeat (5) @(negedge clk);
    chk("R5 irq stays high with channels disabled", {7'd0, irq_n}, 8'h01);
    rd(A_ST, rd_v); chk("R5 no status with channels disabled", rd_v, 8'h00);

    // R6 zero bits unchanged
    wr(A_GLB, 8'h01); wr(A_EN, 8'hFF);
    @(negedge clk); chan_in = ~chan_in;
    repeat (4) @(negedge clk);
    wr(A_ST, 8'h0F);
    rd(A_ST, rd_v); chk("R6 partial clear", rd_v, 8'hF0);
    wr(A_ST, 8'h00);
    rd(A_ST, rd_v); chk("R6 zero write keeps bits", rd_v, 8'hF0);
    wr(A_GLB, 8'h01);
    chk("R8 irq after rearm with pending", {7'd0, irq_n}, 8'h00);
    wr(A_EN, 8'h00);
    chk("R8 irq high when pending masked", {7'd0, irq_n}, 8'h01);
    rd(A_GLB, rd_v); chk("R7 pending masked by enable", rd_v & 8'h03, 8'h01);
    rd(A_ST, rd_v);  chk("R6 status kept while disabled", rd_v, 8'hF0);

    // R4 level-match sweep
    wr(A_MODE, 8'h00);
    for (int p = 0; p < 8; p++) begin
      logic [7:0] d, pol, m, exp;
      d   = 8'(p * 8'h5B) ^ 8'h3C;
      pol = 8'(p * 8'h27);
      m   = 8'hFF >> (p % 4);
      exp = ~(d ^ pol) & m;
      wr(A_EN, 8'h00); wr(A_POL, pol);
      @(negedge clk); chan_in = d;
      repeat (3) @(negedge clk);
      wr(A_ST, 8'hFF);
      rd(A_ST, rd_v); chk("R5 level mode disabled", rd_v, 8'h00);
      wr(A_EN, m);
      rd(A_ST, rd_v); chk($sformatf("R4 level pattern %0d", p), rd_v, exp);
      wr(A_ST, 8'hFF);
      rd(A_ST, rd_v); chk("R6 event wins over clear", rd_v, exp);
      rd(A_GLB, rd_v); chk("R7 level pending flag", rd_v & 8'h03, {6'd0, |exp, 1'b0});
      wr(A_GLB, 8'h01);
      chk("R8 irq follows pending when armed", {7'd0, irq_n}, {7'd0, ~(|exp)});
    end

    // R1 reset mid-run
    do_reset();
    reset_regs_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule